// File: doc/BRIEF.md
# Delayed Transaction Request Queue

This block keeps track of the delayed read and delayed write requests that one direction of a bus bridge has accepted but not yet finished. When a master on the initiating bus starts a cycle that needs a delayed transaction, the block captures the address and the command in a free entry and tells the master to retry. The captured request is offered to the master logic on the target side, which runs it there and later reports that the completion (read data or write status) has been queued.

After that, every new cycle on the initiating bus is compared against the stored entries. When the master comes back with exactly the same request, the block reports a hit so the queued completion can be handed over, and the entry is released. A completed entry is also released when the discard timer of its data queue runs out. There are `N_RD` entries shared by delayed reads and one extra entry that serves only delayed writes. For dual address cycles, the upper 32 address bits sit in their own storage next to each entry and take part in the comparison only when the dual-address flag is set.

Top module: `dly_txn_queue`

## Requirements
- R1: After reset every entry is empty: `iss_valid` is 0, and no request produces `req_hit`.
- R2: A read request (`req_is_write`=0) that matches no stored entry is captured into the lowest-numbered empty read entry (indices 0 to `N_RD`-1). `req_taken` is 1 in that cycle, and from the next cycle the entry is offered on the issue port with the captured address, command, dual-address flag and upper bits.
- R3: A write request (`req_is_write`=1) is captured only into entry `N_RD`, and only while that entry is empty. Read requests never use entry `N_RD`.
- R4: A read request that finds no empty read entry gets `req_taken`=0, and nothing is stored.
- R5: Entries waiting to issue are offered one at a time, lowest index first. A cycle with `iss_valid` and `iss_ready` both 1 marks the offered entry as issued, and the next waiting entry is then offered.
- R6: `cpl_valid` with `cpl_idx` moves an issued entry to the completed state. For an entry that is not in the issued state, the input is ignored.
- R7: A request hits only if the entry is completed and the direction (read or write), address, command and dual-address flag all equal the stored values. On a hit, `req_hit` is 1 and `req_hit_idx` names the entry in that same cycle, and the entry is empty from the next cycle on.
- R8: A request that matches an entry that is waiting or issued is neither captured again nor reported as a hit.
- R9: `dsc_valid` with `dsc_idx` empties a completed entry. For an entry that is waiting or issued, the input is ignored.
- R10: If a hit and a discard target the same entry in the same cycle, the hit is still reported and the entry is freed.
- R11: The stored upper 32 address bits take part in the match only when the dual-address flag is 1. When the flag is 0, differing upper bits still hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Initiating-bus cycle present this clock |
| req_is_write | input | 1 | 1 = delayed write, 0 = delayed read |
| req_addr | input | ADDR_W | Low address of the cycle |
| req_cmd | input | CMD_W | Bus command of the cycle |
| req_dac | input | 1 | Cycle uses a dual address phase |
| req_addr_hi | input | 32 | Upper 32 address bits (only used when `req_dac` is 1) |
| req_taken | output | 1 | Request captured into a new entry |
| req_hit | output | 1 | Cycle is the retry of a completed entry |
| req_hit_idx | output | IDX_W | Entry that hit |
| iss_valid | output | 1 | An entry is waiting to run on the target bus |
| iss_ready | input | 1 | Target-side master accepts the offered entry |
| iss_idx | output | IDX_W | Index of the offered entry |
| iss_is_write | output | 1 | Offered entry is the write entry |
| iss_addr | output | ADDR_W | Stored low address |
| iss_cmd | output | CMD_W | Stored command |
| iss_dac | output | 1 | Stored dual-address flag |
| iss_addr_hi | output | 32 | Stored upper address bits |
| cpl_valid | input | 1 | Completion for `cpl_idx` has been queued |
| cpl_idx | input | IDX_W | Entry whose completion arrived |
| dsc_valid | input | 1 | Discard timer expired for `dsc_idx` |
| dsc_idx | input | IDX_W | Entry whose timer expired |

## Verification
The bench builds the block with its default parameters: three read entries plus the write entry, 32-bit low addresses and 4-bit commands. With only three read entries, a handful of requests is enough to fill every read entry, so the full-queue refusal and the lowest-free choice after a release come up within a few dozen cycles. Using a single write entry means that a second write arriving while the first is still held is always refused. The small index width also keeps the issue order of all four entries visible in one short burst.

// File: rtl/dtq_pkg.sv
// Package: shared state encoding for the delayed transaction request queue.
// Assumes: used by every module of the queue; no other content.
package dtq_pkg;

    // Lifecycle of one request entry.
    typedef enum logic [1:0] {
        ENT_EMPTY  = 2'd0,
        ENT_PEND   = 2'd1,
        ENT_ISSUED = 2'd2,
        ENT_DONE   = 2'd3
    } ent_st_e;

endpackage

// File: rtl/dtq_low_pick.sv
// Module: lowest-index picker.
// Returns whether any request bit is set, and the index of the lowest set bit.
// Assumes: IDX_W is wide enough to hold N-1.
module dtq_low_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    // Scan from the top down so that the lowest set bit is the last one written.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

    // Any request present.
    assign any = |req;

endmodule

// File: rtl/dtq_entry.sv
// Module: one request entry, holding its lifecycle state, the captured request and a retry comparator.
// Assumes: the parent only raises cap_en while the entry is empty. Each control
// input only acts in the state it belongs to, and is ignored in every other state.
module dtq_entry
    import dtq_pkg::*;
#(
    parameter int   ADDR_W = 32,
    parameter int   CMD_W  = 4,
    parameter int   HI_W   = 32,
    parameter logic IS_WR  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [ADDR_W-1:0] cap_addr,
    input  logic [CMD_W-1:0]  cap_cmd,
    input  logic              cap_dac,
    input  logic [HI_W-1:0]   cap_hi,
    input  logic              iss_fire,
    input  logic              cpl_set,
    input  logic              free_set,
    input  logic              cmp_wr,
    output logic              cmp_eq,
    output ent_st_e           st_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [CMD_W-1:0]  cmd_o,
    output logic              dac_o,
    output logic [HI_W-1:0]   hi_o
);

    ent_st_e st_q;

    // Advance the entry through empty, waiting, issued and completed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ENT_EMPTY;
        end else begin
            unique case (st_q)
                ENT_EMPTY:  if (cap_en)   st_q <= ENT_PEND;
                ENT_PEND:   if (iss_fire) st_q <= ENT_ISSUED;
                ENT_ISSUED: if (cpl_set)  st_q <= ENT_DONE;
                ENT_DONE:   if (free_set) st_q <= ENT_EMPTY;
                default:                  st_q <= ENT_EMPTY;
            endcase
        end
    end

    // Latch the request fields on capture; the upper bits go to their own storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o <= '0;
            cmd_o  <= '0;
            dac_o  <= 1'b0;
            hi_o   <= '0;
        end else if (cap_en && st_q == ENT_EMPTY) begin
            addr_o <= cap_addr;
            cmd_o  <= cap_cmd;
            dac_o  <= cap_dac;
            hi_o   <= cap_hi;
        end
    end

    // Compare an incoming cycle with the stored request; upper bits only count for dual address.
    always_comb begin
        cmp_eq = (st_q != ENT_EMPTY) && (cmp_wr == IS_WR)
              && (cap_addr == addr_o) && (cap_cmd == cmd_o)
              && (cap_dac == dac_o) && (!dac_o || cap_hi == hi_o);
    end

    assign st_o = st_q;

endmodule

// File: rtl/dly_txn_queue.sv
// Module: delayed transaction request queue for one bridge direction.
// Entries 0..N_RD-1 hold delayed reads and entry N_RD holds the single delayed write.
// Captures requests, offers them lowest index first to the target side, tracks
// completions and releases an entry on a matching retry or on a discard timeout.
// Assumes: completion and discard indices name existing entries.
module dly_txn_queue
    import dtq_pkg::*;
#(
    parameter int N_RD   = 3,
    parameter int ADDR_W = 32,
    parameter int CMD_W  = 4,
    localparam int N_ENT = N_RD + 1,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_is_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CMD_W-1:0]  req_cmd,
    input  logic              req_dac,
    input  logic [31:0]       req_addr_hi,
    output logic              req_taken,
    output logic              req_hit,
    output logic [IDX_W-1:0]  req_hit_idx,
    output logic              iss_valid,
    input  logic              iss_ready,
    output logic [IDX_W-1:0]  iss_idx,
    output logic              iss_is_write,
    output logic [ADDR_W-1:0] iss_addr,
    output logic [CMD_W-1:0]  iss_cmd,
    output logic              iss_dac,
    output logic [31:0]       iss_addr_hi,
    input  logic              cpl_valid,
    input  logic [IDX_W-1:0]  cpl_idx,
    input  logic              dsc_valid,
    input  logic [IDX_W-1:0]  dsc_idx
);

    localparam int WR_IDX = N_RD;
    localparam int HI_W   = 32;

    ent_st_e           st_a   [N_ENT];
    logic [ADDR_W-1:0] addr_a [N_ENT];
    logic [CMD_W-1:0]  cmd_a  [N_ENT];
    logic              dac_a  [N_ENT];
    logic [HI_W-1:0]   hi_a   [N_ENT];

    logic [N_ENT-1:0] empty_vec, pend_vec, iss_vec, done_vec;
    logic [N_ENT-1:0] match_vec, hit_vec, cap_vec;
    logic             rd_free_any;
    logic [IDX_W-1:0] rd_free_idx;
    logic             hit_any;

    // One entry per slot; the last slot is the dedicated write entry.
    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        dtq_entry #(
            .ADDR_W (ADDR_W),
            .CMD_W  (CMD_W),
            .HI_W   (HI_W),
            .IS_WR  ((g == WR_IDX) ? 1'b1 : 1'b0)
        ) ent_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .cap_en   (cap_vec[g]),
            .cap_addr (req_addr),
            .cap_cmd  (req_cmd),
            .cap_dac  (req_dac),
            .cap_hi   (req_addr_hi),
            .iss_fire (iss_valid && iss_ready && iss_idx == IDX_W'(g)),
            .cpl_set  (cpl_valid && cpl_idx == IDX_W'(g)),
            .free_set (hit_vec[g] || (dsc_valid && dsc_idx == IDX_W'(g))),
            .cmp_wr   (req_is_write),
            .cmp_eq   (match_vec[g]),
            .st_o     (st_a[g]),
            .addr_o   (addr_a[g]),
            .cmd_o    (cmd_a[g]),
            .dac_o    (dac_a[g]),
            .hi_o     (hi_a[g])
        );

        // Decode each entry's state into per-state vectors.
        assign empty_vec[g] = (st_a[g] == ENT_EMPTY);
        assign pend_vec[g]  = (st_a[g] == ENT_PEND);
        assign iss_vec[g]   = (st_a[g] == ENT_ISSUED);
        assign done_vec[g]  = (st_a[g] == ENT_DONE);

        // A hit requires a live cycle and a completed entry.
        assign hit_vec[g] = req_valid && match_vec[g] && done_vec[g];

        // Capture strobe: a read goes to the chosen free read entry, a write to the write entry.
        if (g == WR_IDX) begin : g_wr_cap
            assign cap_vec[g] = req_taken && req_is_write;
        end else begin : g_rd_cap
            assign cap_vec[g] = req_taken && !req_is_write && rd_free_idx == IDX_W'(g);
        end
    end

    // Choose the lowest empty read entry for a new read.
    dtq_low_pick #(.N(N_RD), .IDX_W(IDX_W)) rd_free_i (
        .req (empty_vec[N_RD-1:0]),
        .any (rd_free_any),
        .idx (rd_free_idx)
    );

    // Choose the lowest waiting entry to offer to the target side.
    dtq_low_pick #(.N(N_ENT), .IDX_W(IDX_W)) iss_pick_i (
        .req (pend_vec),
        .any (iss_valid),
        .idx (iss_idx)
    );

    // Encode the index of the entry that hit.
    dtq_low_pick #(.N(N_ENT), .IDX_W(IDX_W)) hit_enc_i (
        .req (hit_vec),
        .any (hit_any),
        .idx (req_hit_idx)
    );

    // A new request is captured only if it duplicates no live entry and a slot of its kind is empty.
    always_comb begin
        req_taken = req_valid && (match_vec == '0)
                 && (req_is_write ? empty_vec[WR_IDX] : rd_free_any);
    end

    assign req_hit = hit_any;

    // Present the stored fields of the offered entry on the target side.
    always_comb begin
        iss_addr     = addr_a[iss_idx];
        iss_cmd      = cmd_a[iss_idx];
        iss_dac      = dac_a[iss_idx];
        iss_addr_hi  = hi_a[iss_idx];
        iss_is_write = (iss_idx == IDX_W'(WR_IDX));
    end

endmodule

// File: rtl/dtq_checker.sv
// Module: property checker for the delayed transaction request queue, attached by bind.
// Assumes: the state vectors come from the entry state decode in the top module.
module dtq_checker #(
    parameter int N_RD  = 3,
    parameter int N_ENT = 4,
    parameter int IDX_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_is_write,
    input logic             req_taken,
    input logic             req_hit,
    input logic [IDX_W-1:0] req_hit_idx,
    input logic             iss_valid,
    input logic [IDX_W-1:0] iss_idx,
    input logic [N_ENT-1:0] empty_vec,
    input logic [N_ENT-1:0] pend_vec,
    input logic [N_ENT-1:0] iss_vec,
    input logic [N_ENT-1:0] done_vec
);

    // A read with every read entry occupied is refused.
    p_no_read_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_write && empty_vec[N_RD-1:0] == '0) |-> !req_taken);

    // A captured write lands in the dedicated write entry.
    p_write_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_taken && req_is_write) |=> pend_vec[N_RD]);

    // The offered entry is waiting and no lower entry is waiting.
    p_lowest_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (pend_vec[iss_idx] && (pend_vec & ~({N_ENT{1'b1}} << iss_idx)) == '0));

    // The entry that hit is empty on the next cycle.
    p_free_on_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_hit |=> empty_vec[$past(req_hit_idx)]);

    // An entry only becomes completed after being issued.
    for (genvar g = 0; g < N_ENT; g++) begin : g_chk
        p_done_after_issue_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(done_vec[g]) |-> $past(iss_vec[g]));
    end

endmodule

bind dly_txn_queue dtq_checker #(
    .N_RD  (N_RD),
    .N_ENT (N_ENT),
    .IDX_W (IDX_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_is_write (req_is_write),
    .req_taken    (req_taken),
    .req_hit      (req_hit),
    .req_hit_idx  (req_hit_idx),
    .iss_valid    (iss_valid),
    .iss_idx      (iss_idx),
    .empty_vec    (empty_vec),
    .pend_vec     (pend_vec),
    .iss_vec      (iss_vec),
    .done_vec     (done_vec)
);

// File: tb/dly_txn_queue_tb_top.sv
// Bench: scoreboard for the delayed transaction request queue.
// The request driver pushes the expected issue item for every capture, and the
// monitor pops and compares items as the target side accepts them.
module dly_txn_queue_tb_top;

    localparam int IDX_W = 2;

    typedef struct packed {
        logic [1:0]  idx;
        logic [31:0] addr;
        logic [3:0]  cmd;
        logic        dac;
        logic [31:0] hi;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_is_write = 1'b0, req_dac = 1'b0;
    logic [31:0] req_addr = '0, req_addr_hi = '0;
    logic [3:0]  req_cmd = '0;
    logic        req_taken, req_hit, iss_valid, iss_is_write, iss_dac;
    logic [1:0]  req_hit_idx, iss_idx;
    logic        iss_ready = 1'b0;
    logic [31:0] iss_addr, iss_addr_hi;
    logic [3:0]  iss_cmd;
    logic        cpl_valid = 1'b0, dsc_valid = 1'b0;
    logic [1:0]  cpl_idx = '0, dsc_idx = '0;

    exp_t expq[$];
    int   n_chk = 0;
    int   n_fail = 0;

    always #2 clk = ~clk;

    dly_txn_queue dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_is_write(req_is_write), .req_addr(req_addr),
        .req_cmd(req_cmd), .req_dac(req_dac), .req_addr_hi(req_addr_hi),
        .req_taken(req_taken), .req_hit(req_hit), .req_hit_idx(req_hit_idx),
        .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_idx(iss_idx),
        .iss_is_write(iss_is_write), .iss_addr(iss_addr), .iss_cmd(iss_cmd),
        .iss_dac(iss_dac), .iss_addr_hi(iss_addr_hi),
        .cpl_valid(cpl_valid), .cpl_idx(cpl_idx),
        .dsc_valid(dsc_valid), .dsc_idx(dsc_idx)
    );

    // Record one check; a failure prints the requirement and both values.
    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // Present one initiating-bus cycle, check the same-cycle response, and push the expected issue item.
    task automatic do_req(input bit wr, input logic [31:0] a, input logic [3:0] c,
                          input bit d, input logic [31:0] h, input bit e_taken,
                          input bit e_hit, input logic [1:0] e_idx, input string rq);
        req_valid = 1'b1; req_is_write = wr; req_addr = a; req_cmd = c;
        req_dac = d; req_addr_hi = h;
        #1;
        chk(req_taken == e_taken, rq, "req_taken", 128'(req_taken), 128'(e_taken));
        chk(req_hit == e_hit, rq, "req_hit", 128'(req_hit), 128'(e_hit));
        if (e_hit) chk(req_hit_idx == e_idx, rq, "req_hit_idx", 128'(req_hit_idx), 128'(e_idx));
        if (e_taken) expq.push_back('{idx: e_idx, addr: a, cmd: c, dac: d, hi: h});
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    // Report a queued completion for one entry.
    task automatic do_cpl(input logic [1:0] i);
        cpl_valid = 1'b1; cpl_idx = i;
        @(posedge clk); #1;
        cpl_valid = 1'b0;
    endtask

    // Signal a discard timeout for one entry.
    task automatic do_dsc(input logic [1:0] i);
        dsc_valid = 1'b1; dsc_idx = i;
        @(posedge clk); #1;
        dsc_valid = 1'b0;
    endtask

    // Accept offered entries for n cycles.
    task automatic issue_n(input int n);
        iss_ready = 1'b1;
        repeat (n) @(posedge clk);
        #1;
        iss_ready = 1'b0;
    endtask

    // Monitor: compare each accepted issue against the scoreboard, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && iss_valid && iss_ready) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R5", "unexpected issue", 128'(iss_idx), 128'(0));
            end else begin
                exp_t e;
                e = expq.pop_front();
                chk(iss_idx == e.idx, "R5", "issue order idx", 128'(iss_idx), 128'(e.idx));
                chk({iss_addr, iss_cmd, iss_dac, iss_addr_hi} == {e.addr, e.cmd, e.dac, e.hi},
                    "R2", "issued fields",
                    128'({iss_addr, iss_cmd, iss_dac, iss_addr_hi}),
                    128'({e.addr, e.cmd, e.dac, e.hi}));
                chk(iss_is_write == (e.idx == 2'd3), "R3", "iss_is_write",
                    128'(iss_is_write), 128'(e.idx == 2'd3));
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #400000;
        chk(1'b0, "R1", "watchdog expired", 128'(0), 128'(1));
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        #1;
        // R1: idle after reset
        chk(iss_valid == 1'b0, "R1", "iss_valid after reset", 128'(iss_valid), 128'(0));
        chk(req_hit == 1'b0, "R1", "req_hit after reset", 128'(req_hit), 128'(0));
        @(posedge clk); #1;

        // R2: read captures into lowest free read entries
        do_req(0, 32'h1000, 4'h6, 0, 32'h0,        1, 0, 2'd0, "R2");
        do_req(0, 32'h2000, 4'h6, 1, 32'hDEADBEEF, 1, 0, 2'd1, "R2");
        // R8: duplicate of a waiting entry
        do_req(0, 32'h1000, 4'h6, 0, 32'h0,        0, 0, 2'd0, "R8");
        do_req(0, 32'h4000, 4'hC, 0, 32'h0,        1, 0, 2'd2, "R2");
        // R4: no read entry left
        do_req(0, 32'h5000, 4'h6, 0, 32'h0,        0, 0, 2'd0, "R4");
        // R3: write entry, then a second write refused
        do_req(1, 32'h3000, 4'h7, 0, 32'h0,        1, 0, 2'd3, "R3");
        do_req(1, 32'h3100, 4'h7, 0, 32'h0,        0, 0, 2'd3, "R3");

        // R5: lowest waiting entry offered first
        chk(iss_valid && iss_idx == 2'd0, "R5", "first offered idx", 128'(iss_idx), 128'(0));
        // R6: completion for a waiting entry is ignored
        do_cpl(2'd0);
        do_req(0, 32'h1000, 4'h6, 0, 32'h0, 0, 0, 2'd0, "R6");
        issue_n(4);
        chk(iss_valid == 1'b0, "R5", "nothing left to offer", 128'(iss_valid), 128'(0));
        chk(expq.size() == 0, "R5", "all items issued", 128'(expq.size()), 128'(0));
        // R8 and R6: retry while issued does not hit
        do_req(0, 32'h1000, 4'h6, 0, 32'h0, 0, 0, 2'd0, "R8");

        do_cpl(2'd0);
        do_cpl(2'd1);
        do_cpl(2'd3);
        // R7: wrong command does not hit
        do_req(0, 32'h1000, 4'h7, 0, 32'h0, 0, 0, 2'd0, "R7");
        // R11: dual address with wrong upper bits does not hit, correct ones do
        do_req(0, 32'h2000, 4'h6, 1, 32'hDEADBEEE, 0, 0, 2'd1, "R11");
        do_req(0, 32'h2000, 4'h6, 1, 32'hDEADBEEF, 0, 1, 2'd1, "R11");
        // R11 and R7: single address ignores upper bits
        do_req(0, 32'h1000, 4'h6, 0, 32'h12345678, 0, 1, 2'd0, "R7");

        // R9: discard on an issued entry ignored; the entry still hits after completion
        do_dsc(2'd2);
        do_cpl(2'd2);
        do_req(0, 32'h4000, 4'hC, 0, 32'h0, 0, 1, 2'd2, "R9");
        // R9: discard frees the completed write entry, so the retry is captured anew
        do_dsc(2'd3);
        do_req(1, 32'h3000, 4'h7, 0, 32'h0, 1, 0, 2'd3, "R9");
        issue_n(1);
        do_cpl(2'd3);

        // R10: hit and discard on the same entry in the same cycle
        dsc_valid = 1'b1; dsc_idx = 2'd3;
        do_req(1, 32'h3000, 4'h7, 0, 32'h0, 0, 1, 2'd3, "R10");
        dsc_valid = 1'b0;
        // R2: freed read entries reused lowest first; R10: write entry free again
        do_req(0, 32'h5000, 4'h6, 0, 32'h0, 1, 0, 2'd0, "R2");
        do_req(1, 32'h3100, 4'h7, 0, 32'h0, 1, 0, 2'd3, "R10");
        issue_n(2);
        chk(expq.size() == 0, "R5", "final queue drained", 128'(expq.size()), 128'(0));
        chk(iss_valid == 1'b0, "R5", "final idle", 128'(iss_valid), 128'(0));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule